// File: doc/BRIEF.md
# Display Serial Command and Read Engine

This block drives a small display controller over a four-wire serial link: clock, data out, data in and chip select, plus a separate line that marks each byte as an opcode or as a parameter. A host hands it one command at a time as an opcode byte with a length. Parameter bytes then arrive on a second byte stream. The engine shifts everything out under a single chip-select assertion. The opcode travels with the select line low. The parameters follow with it high.

Each opcode is decoded to choose the write path or the read path. Opcodes in a fixed read set send only the opcode. The engine then clocks in the panel's answer at a slower bit rate and returns the bytes on a read stream. Two of these opcodes return a reply that starts one bit late, and the engine shifts that reply back into byte alignment. A separate sequencer produces the panel's active-low reset pulse and the settling wait that follows it.

Top module: `dbi_serial_engine`

## Requirements
- R1: Every command begins with its opcode, sent as 8 bits MSB first, with `dc` low and `cs_n` low.
- R2: Parameter bytes follow the opcode, sent MSB first with `dc` high, inside the same `cs_n` low period. `dc` only changes while `sclk` is low.
- R3: When a write command has `req_len` = 0, `cs_n` returns high right after the opcode byte. No parameter byte is consumed.
- R4: The read path is taken only for opcodes 0x2E, 0x3E, 0x04, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x06, 0x07, 0x08, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 and 0xA8. Every other opcode (for example 0x11, 0x2A or 0xDA) takes the write path.
- R5: The number of bytes a read returns depends only on the opcode: 2 for 0x2E and 0x3E, 3 for 0x04, 4 for 0x09, and 1 for any other read opcode. For reads other than 0x04 and 0x09, `req_len` has no effect.
- R6: For 0x04 and 0x09, the engine clocks in one more byte than it returns. Returned byte i is (raw[i] << 1) | (raw[i+1] >> 7).
- R7: A request for 0x04 with `req_len` not equal to 3, or for 0x09 with `req_len` not equal to 4, is consumed and rejected. The engine raises `req_err` for one cycle and produces no bus activity.
- R8: A read sends its opcode and then clocks in the reply, all at a bit period of 2*RD_HALF clock cycles and within one `cs_n` low period. Writes use a bit period of 2*WR_HALF cycles. While reading, `mosi` sends 0x00 bytes.
- R9: For opcode 0x2C with `req_swap` = 0, each pair of incoming parameter bytes (b0, b1) is sent as b1 and then b0. An unpaired last byte is sent as it is. When `req_swap` = 1, bytes are sent in the order they arrive.
- R10: A `rst_start` pulse drives `panel_rst_n` low for RST_LOW_CYC cycles and then waits RST_WAIT_CYC cycles before `panel_ready` goes high. `rst_start` has no effect while a sequence is running.
- R11: `rd_valid` stays high with `rd_data` unchanged until `rd_ready`. The engine stalls the bus while it waits. `busy` is high from request acceptance until `cs_n` is released.
- R12: The serial clock runs in mode 0. `sclk` is low while idle. `mosi` changes only while `sclk` is low. `miso` is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Engine accepts a request |
| req_opcode | input | 8 | Command opcode |
| req_len | input | LEN_W | Parameter count for writes, expected reply length for ID/status reads |
| req_swap | input | 1 | Send 0x2C parameters in arrival order |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| par_valid | input | 1 | Parameter byte valid |
| par_ready | output | 1 | Parameter byte taken |
| par_data | input | 8 | Parameter byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Command in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the panel |
| miso | input | 1 | Serial data from the panel |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Low for the opcode, high for parameters |
| rst_start | input | 1 | Start the panel reset sequence |
| panel_rst_n | output | 1 | Panel reset, active low |
| panel_ready | output | 1 | Reset sequence complete |

## Verification
The hardest case to reach is the realignment of a read whose reply starts one bit late. The bench uses a panel model that drives `miso` on falling `sclk` edges. For 0x04 and 0x09 it sends a leading 1 bit before the data bytes, so any byte built without the shift comes out visibly wrong. The read stream is also throttled by a `rd_ready` pattern that stalls between reply bytes, so the realignment has to hold across paused clocking. A monitor measures the bit period of every byte to tell read rate from write rate.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

  localparam logic [7:0] OP_GET_ID     = 8'h04;
  localparam logic [7:0] OP_GET_STATUS = 8'h09;
  localparam logic [7:0] OP_MEM_WRITE  = 8'h2C;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_PFETCH, ST_PFETCH2, ST_PSEND, ST_RSHIFT, ST_ROUT, ST_END
  } eng_state_t;

  typedef enum logic [1:0] {RS_IDLE, RS_LOW, RS_WAIT, RS_DONE} rst_state_t;

  // R4: opcodes answered by the panel
  function automatic logic op_is_read(input logic [7:0] op);
    case (op)
      8'h2E, 8'h3E, 8'h04, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F,
      8'h06, 8'h07, 8'h08, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F, 8'hA1, 8'hA8:
        return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // R5: reply length per read opcode
  function automatic logic [2:0] op_reply_len(input logic [7:0] op);
    case (op)
      8'h2E, 8'h3E: return 3'd2;
      OP_GET_ID:    return 3'd3;
      OP_GET_STATUS: return 3'd4;
      default:      return 3'd1;
    endcase
  endfunction

  // R6: replies preceded by one dummy bit
  function automatic logic op_late_reply(input logic [7:0] op);
    return (op == OP_GET_ID) || (op == OP_GET_STATUS);
  endfunction

endpackage

// File: rtl/dbi_byte_shifter.sv
module dbi_byte_shifter #(
  parameter int WR_HALF = 2,
  parameter int RD_HALF = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       slow,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int HMAX = (RD_HALF > WR_HALF) ? RD_HALF : WR_HALF;
  localparam int CW   = $clog2(HMAX) + 1;

  logic          act_q, act_n, slow_q, slow_n, sclk_q, sclk_n, done_q, done_n;
  logic [7:0]    sh_q, sh_n, rx_q, rx_n;
  logic [2:0]    bit_q, bit_n;
  logic [CW-1:0] cnt_q, cnt_n, lim;

  assign lim = slow_q ? CW'(RD_HALF - 1) : CW'(WR_HALF - 1);

  always_comb begin
    act_n = act_q; slow_n = slow_q; sclk_n = sclk_q; done_n = 1'b0;
    sh_n = sh_q; rx_n = rx_q; bit_n = bit_q; cnt_n = cnt_q;
    if (start) begin
      act_n = 1'b1; slow_n = slow; sclk_n = 1'b0;
      sh_n = tx_byte; bit_n = '0; cnt_n = '0;
    end else if (act_q) begin
      if (cnt_q == lim) begin
        cnt_n = '0;
        if (!sclk_q) begin
          sclk_n = 1'b1;
          rx_n   = {rx_q[6:0], miso};
        end else begin
          sclk_n = 1'b0;
          if (bit_q == 3'd7) begin
            act_n  = 1'b0;
            done_n = 1'b1;
          end else begin
            bit_n = bit_q + 3'd1;
            sh_n  = {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; slow_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      sh_q <= '0; rx_q <= '0; bit_q <= '0; cnt_q <= '0;
    end else begin
      act_q <= act_n; slow_q <= slow_n; sclk_q <= sclk_n; done_q <= done_n;
      sh_q <= sh_n; rx_q <= rx_n; bit_q <= bit_n; cnt_q <= cnt_n;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = sh_q[7];
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/dbi_panel_reset.sv
module dbi_panel_reset
  import dbi_pkg::*;
#(
  parameter int LOW_CYC  = 2000,
  parameter int WAIT_CYC = 12000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic panel_rst_n,
  output logic ready
);
  localparam int LMAX = (LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC;
  localparam int CW   = $clog2(LMAX + 1);

  rst_state_t    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q;
    case (st_q)
      RS_IDLE, RS_DONE: if (start) begin st_n = RS_LOW; cnt_n = '0; end
      RS_LOW: begin
        if (cnt_q == CW'(LOW_CYC - 1)) begin st_n = RS_WAIT; cnt_n = '0; end
        else cnt_n = cnt_q + CW'(1);
      end
      RS_WAIT: begin
        if (cnt_q == CW'(WAIT_CYC - 1)) begin st_n = RS_DONE; cnt_n = '0; end
        else cnt_n = cnt_q + CW'(1);
      end
      default: st_n = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RS_IDLE; cnt_q <= '0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n;
    end
  end

  assign panel_rst_n = (st_q != RS_LOW);
  assign ready       = (st_q == RS_DONE);
endmodule

// File: rtl/dbi_serial_engine.sv
module dbi_serial_engine
  import dbi_pkg::*;
#(
  parameter int WR_HALF      = 2,
  parameter int RD_HALF      = 8,
  parameter int LEN_W        = 16,
  parameter int RST_LOW_CYC  = 2000,
  parameter int RST_WAIT_CYC = 12000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_opcode,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_swap,
  output logic             req_err,
  input  logic             par_valid,
  output logic             par_ready,
  input  logic [7:0]       par_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             dc,
  input  logic             rst_start,
  output logic             panel_rst_n,
  output logic             panel_ready
);
  eng_state_t       st_q, st_n;
  logic [LEN_W-1:0] rem_q, rem_n;
  logic             pair_q, pair_n, rd_q, rd_n, late_q, late_n, first_q, first_n;
  logic             pend_q, pend_n, dc_q, dc_n, err_q, err_n;
  logic [7:0]       hold_q, hold_n, out_q, out_n;
  logic [6:0]       prev_q, prev_n;
  logic [2:0]       ocnt_q, ocnt_n, nrd_q, nrd_n;

  logic       sh_start, sh_slow, sh_done;
  logic [7:0] sh_tx, sh_rx;
  logic       dec_rd, dec_late, bad_len;
  logic [2:0] dec_len;

  assign dec_rd   = op_is_read(req_opcode);
  assign dec_late = op_late_reply(req_opcode);
  assign dec_len  = op_reply_len(req_opcode);
  assign bad_len  = dec_rd && dec_late && (req_len != LEN_W'(dec_len));

  always_comb begin
    st_n = st_q; rem_n = rem_q; pair_n = pair_q; rd_n = rd_q; late_n = late_q;
    first_n = first_q; pend_n = pend_q; dc_n = dc_q; err_n = 1'b0;
    hold_n = hold_q; out_n = out_q; prev_n = prev_q; ocnt_n = ocnt_q; nrd_n = nrd_q;
    sh_start = 1'b0; sh_tx = 8'h00; sh_slow = rd_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (bad_len) err_n = 1'b1;
        else begin
          rd_n = dec_rd; late_n = dec_late; nrd_n = dec_len; rem_n = req_len;
          pair_n = (req_opcode == OP_MEM_WRITE) && !req_swap; dc_n = 1'b0;
          sh_start = 1'b1; sh_tx = req_opcode; sh_slow = dec_rd; st_n = ST_OP;
        end
      end
      ST_OP: if (sh_done) begin
        if (rd_q) begin
          sh_start = 1'b1; first_n = late_q; ocnt_n = '0; st_n = ST_RSHIFT;
        end else if (rem_q == '0) st_n = ST_END;
        else st_n = ST_PFETCH;
      end
      ST_PFETCH: if (par_valid) begin
        if (pair_q && rem_q >= LEN_W'(2)) begin
          hold_n = par_data; st_n = ST_PFETCH2;
        end else begin
          dc_n = 1'b1; sh_start = 1'b1; sh_tx = par_data; st_n = ST_PSEND;
        end
      end
      ST_PFETCH2: if (par_valid) begin
        dc_n = 1'b1; sh_start = 1'b1; sh_tx = par_data; pend_n = 1'b1; st_n = ST_PSEND;
      end
      ST_PSEND: if (sh_done) begin
        rem_n = rem_q - LEN_W'(1);
        if (pend_q) begin
          sh_start = 1'b1; sh_tx = hold_q; pend_n = 1'b0;
        end else if (rem_q == LEN_W'(1)) st_n = ST_END;
        else st_n = ST_PFETCH;
      end
      ST_RSHIFT: if (sh_done) begin
        prev_n = sh_rx[6:0];
        if (first_q) begin
          first_n = 1'b0; sh_start = 1'b1;
        end else begin
          out_n = late_q ? {prev_q, sh_rx[7]} : sh_rx;
          st_n  = ST_ROUT;
        end
      end
      ST_ROUT: if (rd_ready) begin
        if (ocnt_q == nrd_q - 3'd1) st_n = ST_END;
        else begin
          ocnt_n = ocnt_q + 3'd1; sh_start = 1'b1; st_n = ST_RSHIFT;
        end
      end
      ST_END:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; rem_q <= '0; pair_q <= 1'b0; rd_q <= 1'b0; late_q <= 1'b0;
      first_q <= 1'b0; pend_q <= 1'b0; dc_q <= 1'b0; err_q <= 1'b0;
      hold_q <= '0; out_q <= '0; prev_q <= '0; ocnt_q <= '0; nrd_q <= '0;
    end else begin
      st_q <= st_n; rem_q <= rem_n; pair_q <= pair_n; rd_q <= rd_n; late_q <= late_n;
      first_q <= first_n; pend_q <= pend_n; dc_q <= dc_n; err_q <= err_n;
      hold_q <= hold_n; out_q <= out_n; prev_q <= prev_n; ocnt_q <= ocnt_n; nrd_q <= nrd_n;
    end
  end

  dbi_byte_shifter #(.WR_HALF(WR_HALF), .RD_HALF(RD_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .slow(sh_slow), .tx_byte(sh_tx),
    .miso(miso), .sclk(sclk), .mosi(mosi), .done(sh_done), .rx_byte(sh_rx)
  );

  dbi_panel_reset #(.LOW_CYC(RST_LOW_CYC), .WAIT_CYC(RST_WAIT_CYC)) u_prst (
    .clk(clk), .rst_n(rst_n), .start(rst_start),
    .panel_rst_n(panel_rst_n), .ready(panel_ready)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign par_ready = (st_q == ST_PFETCH) || (st_q == ST_PFETCH2);
  assign rd_valid  = (st_q == ST_ROUT);
  assign rd_data   = out_q;
  assign busy      = (st_q != ST_IDLE);
  assign cs_n      = (st_q == ST_IDLE) || (st_q == ST_END);
  assign dc        = dc_q;
  assign req_err   = err_q;
endmodule

// File: rtl/dbi_serial_engine_chk.sv
module dbi_serial_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       dc,
  input logic       busy,
  input logic       req_err,
  input logic       req_ready,
  input logic       par_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       panel_rst_n,
  input logic       panel_ready
);
  // R12: clock parked low outside a command
  a_r12_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R12: data line moves only in the low phase
  a_r12_mosi_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);
  // R2: select line moves only in the low phase
  a_r2_dc_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dc) |-> !sclk);
  // R11: chip select only inside a busy window
  a_r11_cs_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  // R11: read byte held until taken
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R11: request and parameter streams never open together
  a_r11_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && par_ready));
  // R7: rejection leaves the bus quiet
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (cs_n && !busy));
  // R10: ready implies reset released
  a_r10_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
    panel_ready |-> panel_rst_n);
endmodule

bind dbi_serial_engine dbi_serial_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .dc(dc),
  .busy(busy), .req_err(req_err), .req_ready(req_ready), .par_ready(par_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .panel_rst_n(panel_rst_n), .panel_ready(panel_ready)
);

// File: tb/dbi_serial_engine_tb.sv
`timescale 1ns/1ps
module dbi_serial_engine_tb;
  localparam int WRH = 2, RDH = 4, LW = 8, RLOW = 20, RWAIT = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_swap = 0, par_valid = 0, rd_ready = 1, miso = 0, rst_start = 0;
  logic [7:0] req_opcode = 0, par_data = 0;
  logic [LW-1:0] req_len = 0;
  logic req_ready, req_err, par_ready, rd_valid, busy, sclk, mosi, cs_n, dc;
  logic panel_rst_n, panel_ready;
  logic [7:0] rd_data;

  dbi_serial_engine #(.WR_HALF(WRH), .RD_HALF(RDH), .LEN_W(LW),
                      .RST_LOW_CYC(RLOW), .RST_WAIT_CYC(RWAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_len(req_len), .req_swap(req_swap), .req_err(req_err),
    .par_valid(par_valid), .par_ready(par_ready), .par_data(par_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .dc(dc),
    .rst_start(rst_start), .panel_rst_n(panel_rst_n), .panel_ready(panel_ready)
  );

  int checks = 0, fails = 0;
  logic [10:0] bus_q[$];   // {frame end, dc, slow rate, byte}
  logic [7:0]  rdx_q[$];
  logic [63:0] resp = '0;
  logic [7:0]  pb[0:15];
  bit stall_en = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit tb_is_read(input logic [7:0] op);
    case (op)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E,
      8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F, 8'hA1, 8'hA8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int tb_rd_len(input logic [7:0] op);
    if (op == 8'h2E || op == 8'h3E) return 2;
    if (op == 8'h04) return 3;
    if (op == 8'h09) return 4;
    return 1;
  endfunction

  // bus monitor and panel model
  logic sclk_d = 0, cs_d = 1;
  int bitc = 0, rises = 0, cyc = 0, t0 = 0, per = 0;
  logic [7:0] shreg = 0;
  always @(negedge clk) begin
    logic [10:0] got, exp;
    cyc++;
    if (sclk && !sclk_d) begin
      shreg = {shreg[6:0], mosi};
      if (bitc == 0) t0 = cyc;
      if (bitc == 1) per = cyc - t0;
      bitc++; rises++;
      if (bitc == 8) begin
        bitc = 0;
        got = {1'b0, dc, (per == 2*RDH), shreg};
        if (bus_q.size() == 0) chk(0, "R1 R2 R3 R7 unexpected bus byte", got, 11'h7ff);
        else begin
          exp = bus_q.pop_front();
          chk(got == exp, "R1 R2 R4 R8 R9 bus byte", got, exp);
        end
      end
    end
    if (!sclk && sclk_d && rises >= 8 && rises < 72) miso = resp[63 - (rises - 8)];
    if (!cs_n && cs_d) begin rises = 0; bitc = 0; end
    if (cs_n && !cs_d) begin
      if (bus_q.size() == 0) chk(0, "R3 unexpected frame end", 11'h400, 0);
      else begin
        exp = bus_q.pop_front();
        chk(exp == 11'h400 && bitc == 0, "R3 frame end", exp, 11'h400);
      end
    end
    sclk_d = sclk; cs_d = cs_n;
  end

  // read stream scoreboard
  logic [7:0] last_rd = 0;
  logic       held = 0;
  always @(negedge clk) begin
    if (held) chk(rd_valid && rd_data == last_rd, "R11 read byte held", rd_data, last_rd);
    held = rd_valid && !rd_ready;
    last_rd = rd_data;
    if (rd_valid && rd_ready) begin
      if (rdx_q.size() == 0) chk(0, "R5 unexpected read byte", rd_data, 0);
      else chk(rd_data == rdx_q[0], "R5 R6 read byte", rd_data, rdx_q[0]);
      if (rdx_q.size() != 0) void'(rdx_q.pop_front());
    end
  end

  int stall_cnt = 0;
  initial forever begin
    @(posedge clk); #1;
    rd_ready = stall_en ? (stall_cnt % 3 == 2) : 1'b1;
    stall_cnt++;
  end

  task automatic run_cmd(input logic [7:0] op, input int len, input bit swap);
    bit rd = tb_is_read(op);
    bus_q.push_back({1'b0, 1'b0, rd, op});
    if (rd) begin
      int n = tb_rd_len(op);
      int dm = (op == 8'h04 || op == 8'h09) ? 1 : 0;
      int pos = 63;
      resp = '0;
      if (dm != 0) begin resp[63] = 1'b1; pos = 62; end
      for (int k = 0; k < n; k++) begin
        logic [7:0] d = op * 8'd7 + 8'(k) * 8'd29 + 8'h93;
        rdx_q.push_back(d);
        for (int b = 7; b >= 0; b--) begin resp[pos] = d[b]; pos--; end
      end
      for (int k = 0; k < n + dm; k++) bus_q.push_back({1'b0, 1'b0, 1'b1, 8'h00});
    end else begin
      int k = 0;
      for (int j = 0; j < len; j++) pb[j] = op + 8'(j) * 8'h1d + 8'h41;
      while (k < len) begin
        if (op == 8'h2C && !swap && k + 1 < len) begin
          bus_q.push_back({1'b0, 1'b1, 1'b0, pb[k+1]});
          bus_q.push_back({1'b0, 1'b1, 1'b0, pb[k]});
          k += 2;
        end else begin
          bus_q.push_back({1'b0, 1'b1, 1'b0, pb[k]});
          k++;
        end
      end
    end
    bus_q.push_back(11'h400);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_opcode = op; req_len = LW'(len); req_swap = swap;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
    if (!rd) begin
      for (int j = 0; j < len; j++) begin
        par_valid = 1; par_data = pb[j];
        while (!par_ready) @(negedge clk);
        @(negedge clk);
      end
      par_valid = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(bus_q.size() == 0, "R3 R5 all bus bytes seen", bus_q.size(), 0);
    chk(rdx_q.size() == 0, "R5 all read bytes seen", rdx_q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lc, wc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0, "R12 idle bus", {cs_n, sclk}, 2'b10);
    chk(busy == 0 && req_ready == 1 && rd_valid == 0, "R11 idle handshake", {busy, req_ready, rd_valid}, 3'b010);
    chk(panel_rst_n == 1 && panel_ready == 0, "R10 reset idle", {panel_rst_n, panel_ready}, 2'b10);

    // R10 reset sequence with ignored restart during wait
    rst_start = 1; @(negedge clk); rst_start = 0;
    lc = 0; while (!panel_rst_n) begin lc++; @(negedge clk); end
    chk(lc == RLOW, "R10 low time", lc, RLOW);
    wc = 0;
    while (!panel_ready) begin
      if (wc == 5) rst_start = 1; else rst_start = 0;
      if (!panel_rst_n) chk(0, "R10 restart ignored", 0, 1);
      wc++; @(negedge clk);
    end
    rst_start = 0;
    chk(wc == RWAIT, "R10 wait time", wc, RWAIT);

    run_cmd(8'h11, 0, 0);   // R3 no parameters
    run_cmd(8'h2A, 4, 0);   // R2 R4 write path
    run_cmd(8'hDA, 0, 0);   // R4 not in read set
    run_cmd(8'h0A, 5, 0);   // R5 req_len ignored, R8 rate
    run_cmd(8'h2E, 0, 0);   // R5 two bytes
    run_cmd(8'h04, 3, 0);   // R6 realignment
    stall_en = 1;
    run_cmd(8'h09, 4, 0);   // R6 R11 stalled realignment
    run_cmd(8'h52, 1, 0);   // R4 R11
    stall_en = 0;
    run_cmd(8'h2C, 5, 0);   // R9 pair swap and odd tail
    run_cmd(8'h2C, 4, 1);   // R9 arrival order

    // R7 mismatched length for status read
    @(negedge clk);
    req_valid = 1; req_opcode = 8'h09; req_len = LW'(2); req_swap = 0;
    @(negedge clk);
    req_valid = 0;
    chk(req_err == 1 && busy == 0 && cs_n == 1, "R7 reject", {req_err, busy, cs_n}, 3'b101);
    @(negedge clk);
    chk(req_err == 0, "R7 one-cycle pulse", req_err, 0);
    repeat (40) @(negedge clk);
    chk(cs_n == 1 && rdx_q.size() == 0, "R7 no bus activity", cs_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule